// File: doc/BRIEF.md
# System Integrity Status and Control Register

This block is one 8-bit control and status register in a microcontroller's system-integrity logic. It records which of two hardware events caused the last reset: a low-supply reset or a watchdog reset. It shows the current state of a supply-voltage monitor and a clock-failure detector, and it raises two interrupt requests. The voltage request fires on every change of the monitor flag. The clock request is a level that follows the clock-failure flag.

The CPU uses the register through a simple strobe bus. A write sets three control bits directly. The two reset-cause flags are write-zero-to-clear. Three bit positions are read-only. The voltage monitor input and the oscillator-recovered input come from other clock or analog domains, so each passes through a synchronizer before it is used. Two option straps enable the low-voltage and clock-monitor functions. Single-cycle pulses report each reset source as it occurs.

Top module: `sysint_status_reg`

## Requirements
- R1: After the power-on reset `rst_n` and with the monitor inputs low, `bus_rdata` reads 8'h00 and both interrupt outputs are low.
- R2: A write (`bus_sel` and `bus_wr`) loads bit 7 (monitor source select), bit 6 (voltage interrupt enable) and bit 2 (clock interrupt enable) from `bus_wdata`. Writes to bits 5, 3 and 1 have no effect, and bit 3 always reads 0.
- R3: Bit 4 (low-supply reset flag) and bit 0 (watchdog reset flag) are cleared by writing 0 to them. Writing 1 leaves them unchanged.
- R4: A `lvd_rst_evt` pulse sets bit 4 and clears bit 0. A `wdg_rst_evt` pulse sets bit 0 unless `lvd_rst_evt` is high in the same cycle. Both events take priority over a write in the same cycle.
- R5: Any reset-source pulse (low-supply, watchdog or external) clears bits 7, 6 and 2 and the pending voltage request. An external reset pulse leaves bits 4 and 0 unchanged.
- R6: Bit 5 shows the voltage-monitor input selected by bit 7 (0: `vmon_supply_async`, 1: `vmon_pin_async`), delayed by the two-flop synchronizer. It reads 0 while `lvd_opt_en` is low.
- R7: While bit 6 is set, each change of bit 5, rising or falling, latches a pending request on `vmon_irq` one cycle after bit 5 changes. With bit 6 clear, a change latches nothing.
- R8: `vmon_irq_ack` clears the pending voltage request. A new change in the same cycle wins over the acknowledge.
- R9: A `css_fail_evt` pulse sets bit 1. A read (`bus_sel` and `bus_rd`) clears bit 1 only while the synchronized `osc_ok_async` is high. Otherwise the read leaves bit 1 set.
- R10: While `css_opt_en` is low, bit 1 reads 0 and `css_irq` stays low.
- R11: `css_irq` is high exactly when bit 1 reads 1 and bit 2 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| bus_sel | input | 1 | Register select strobe |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (for clear-on-read) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Register read value |
| lvd_opt_en | input | 1 | Option strap: low-voltage monitor enabled |
| css_opt_en | input | 1 | Option strap: clock monitor enabled |
| vmon_supply_async | input | 1 | Supply-monitor comparator output, asynchronous |
| vmon_pin_async | input | 1 | External detect pin comparator output, asynchronous |
| osc_ok_async | input | 1 | Main oscillator recovered, asynchronous |
| css_fail_evt | input | 1 | Pulse: backup oscillator switched in |
| lvd_rst_evt | input | 1 | Pulse: low-supply reset occurred |
| wdg_rst_evt | input | 1 | Pulse: watchdog reset occurred |
| ext_rst_evt | input | 1 | Pulse: external pin reset occurred |
| vmon_irq_ack | input | 1 | CPU has entered the voltage interrupt routine |
| vmon_irq | output | 1 | Pending voltage-change interrupt request |
| css_irq | output | 1 | Clock-failure interrupt request |

## Verification
The assertions assume that the reset-source and clock-failure inputs are single-cycle pulses in the register clock domain. They also assume that the asynchronous monitor inputs are settled before they are sampled and change only now and then. The bench drives every input on the falling clock edge. During the random phase it holds both monitor inputs at the same level, so that clearing the source select cannot cause a hidden change. Changes on the monitor inputs are made only in directed steps, spaced far enough apart that each one passes the synchronizer alone.

// File: rtl/sysint_pkg.sv
package sysint_pkg;
  localparam int REG_W    = 8;
  localparam int B_SRC    = 7;
  localparam int B_VIE    = 6;
  localparam int B_VFLG   = 5;
  localparam int B_LVR    = 4;
  localparam int B_RSV    = 3;
  localparam int B_CIE    = 2;
  localparam int B_CFD    = 1;
  localparam int B_WDR    = 0;

  typedef struct packed {
    logic src_sel;
    logic vmon_ie;
    logic css_ie;
  } ctrl_t;

  function automatic logic [REG_W-1:0] pack_status(
    input ctrl_t c, input logic vflag, input logic lvr,
    input logic cfd, input logic wdr);
    logic [REG_W-1:0] v;
    v        = '0;
    v[B_SRC] = c.src_sel;
    v[B_VIE] = c.vmon_ie;
    v[B_VFLG]= vflag;
    v[B_LVR] = lvr;
    v[B_RSV] = 1'b0;
    v[B_CIE] = c.css_ie;
    v[B_CFD] = cfd;
    v[B_WDR] = wdr;
    return v;
  endfunction

  function automatic ctrl_t ctrl_from_word(input logic [REG_W-1:0] w);
    ctrl_t c;
    c.src_sel = w[B_SRC];
    c.vmon_ie = w[B_VIE];
    c.css_ie  = w[B_CIE];
    return c;
  endfunction

  // write-zero-to-clear: a written 0 drops the flag, a written 1 keeps it
  function automatic logic w0c_keep(input logic cur, input logic wr,
                                    input logic wbit);
    return cur & ~(wr & ~wbit);
  endfunction
endpackage

// File: rtl/sysint_sync.sv
module sysint_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], d_async};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/sysint_rst_cause.sv
module sysint_rst_cause (
  input  logic clk,
  input  logic rst_n,
  input  logic lvd_evt,
  input  logic wdg_evt,
  input  logic wr,
  input  logic wbit_lvr,
  input  logic wbit_wdr,
  output logic lvr_flag,
  output logic wdr_flag
);
  import sysint_pkg::*;

  logic lvr_q, wdr_q;
  logic lvr_wclr, wdr_wclr;

  assign lvr_wclr = wr & ~wbit_lvr;
  assign wdr_wclr = wr & ~wbit_wdr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvr_q <= 1'b0;
      wdr_q <= 1'b0;
    end else begin
      if (lvd_evt) lvr_q <= 1'b1;
      else         lvr_q <= w0c_keep(lvr_q, wr, wbit_lvr);

      if (lvd_evt)      wdr_q <= 1'b0;
      else if (wdg_evt) wdr_q <= 1'b1;
      else              wdr_q <= w0c_keep(wdr_q, wr, wbit_wdr);
    end
  end

  assign lvr_flag = lvr_q;
  assign wdr_flag = wdr_q;

  p_lvd_clears_wdr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    lvd_evt |=> (!wdr_q && lvr_q));
  p_wdg_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wdg_evt && !lvd_evt) |=> wdr_q);
  p_lvr_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!lvd_evt && !lvr_wclr) |=> $stable(lvr_q));
  p_wdr_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!lvd_evt && !wdg_evt && !wdr_wclr) |=> $stable(wdr_q));
endmodule

// File: rtl/sysint_volt_irq.sv
module sysint_volt_irq #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic src_sel,
  input  logic supply_async,
  input  logic pin_async,
  input  logic mon_en,
  input  logic ie,
  input  logic ack,
  input  logic sys_clr,
  output logic flag,
  output logic irq
);
  logic sel_async, flag_s, flag_prev, toggle, set_req, pend_q;

  assign sel_async = src_sel ? pin_async : supply_async;

  sysint_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_async(sel_async), .q(flag_s));

  assign flag    = flag_s & mon_en;
  assign toggle  = flag ^ flag_prev;
  assign set_req = toggle & ie;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_prev <= 1'b0;
      pend_q    <= 1'b0;
    end else begin
      flag_prev <= flag;
      if (sys_clr)      pend_q <= 1'b0;
      else if (set_req) pend_q <= 1'b1;
      else if (ack)     pend_q <= 1'b0;
    end
  end

  assign irq = pend_q;

  p_toggle_pends_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (set_req && !sys_clr) |=> pend_q);
  p_pend_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend_q) |-> $past(set_req));
  p_ack_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !set_req) |=> !pend_q);
  p_sysclr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sys_clr |=> !pend_q);
endmodule

// File: rtl/sysint_clkfail.sv
module sysint_clkfail #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic opt_en,
  input  logic fail_evt,
  input  logic osc_ok_async,
  input  logic rd,
  input  logic ie,
  output logic flag,
  output logic irq
);
  logic osc_ok_s, cfd_q, rd_clr;

  sysint_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_async(osc_ok_async), .q(osc_ok_s));

  assign rd_clr = rd & osc_ok_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cfd_q <= 1'b0;
    else if (fail_evt) cfd_q <= 1'b1;
    else if (rd_clr)   cfd_q <= 1'b0;
  end

  assign flag = cfd_q & opt_en;
  assign irq  = flag & ie;

  p_cfd_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fail_evt |=> cfd_q);
  p_cfd_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfd_q && !rd_clr) |=> cfd_q);
  p_cfd_clr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && !fail_evt) |=> !cfd_q);
endmodule

// File: rtl/sysint_status_reg.sv
module sysint_status_reg #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_sel,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic       lvd_opt_en,
  input  logic       css_opt_en,
  input  logic       vmon_supply_async,
  input  logic       vmon_pin_async,
  input  logic       osc_ok_async,
  input  logic       css_fail_evt,
  input  logic       lvd_rst_evt,
  input  logic       wdg_rst_evt,
  input  logic       ext_rst_evt,
  input  logic       vmon_irq_ack,
  output logic       vmon_irq,
  output logic       css_irq
);
  import sysint_pkg::*;

  ctrl_t ctrl_q;
  logic  wr_en, rd_en, any_rst_evt;
  logic  vflag, cfd_flag, lvr_flag, wdr_flag;

  assign wr_en       = bus_sel & bus_wr;
  assign rd_en       = bus_sel & bus_rd;
  assign any_rst_evt = lvd_rst_evt | wdg_rst_evt | ext_rst_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           ctrl_q <= '0;
    else if (any_rst_evt) ctrl_q <= '0;
    else if (wr_en)       ctrl_q <= ctrl_from_word(bus_wdata);
  end

  sysint_rst_cause u_cause (
    .clk(clk), .rst_n(rst_n),
    .lvd_evt(lvd_rst_evt), .wdg_evt(wdg_rst_evt),
    .wr(wr_en), .wbit_lvr(bus_wdata[B_LVR]), .wbit_wdr(bus_wdata[B_WDR]),
    .lvr_flag(lvr_flag), .wdr_flag(wdr_flag));

  sysint_volt_irq #(.SYNC_STAGES(SYNC_STAGES)) u_volt (
    .clk(clk), .rst_n(rst_n),
    .src_sel(ctrl_q.src_sel), .supply_async(vmon_supply_async),
    .pin_async(vmon_pin_async), .mon_en(lvd_opt_en),
    .ie(ctrl_q.vmon_ie), .ack(vmon_irq_ack), .sys_clr(any_rst_evt),
    .flag(vflag), .irq(vmon_irq));

  sysint_clkfail #(.SYNC_STAGES(SYNC_STAGES)) u_clk (
    .clk(clk), .rst_n(rst_n), .opt_en(css_opt_en),
    .fail_evt(css_fail_evt), .osc_ok_async(osc_ok_async),
    .rd(rd_en), .ie(ctrl_q.css_ie), .flag(cfd_flag), .irq(css_irq));

  assign bus_rdata = pack_status(ctrl_q, vflag, lvr_flag, cfd_flag, wdr_flag);

  p_ctrl_clr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    any_rst_evt |=> (bus_rdata[B_SRC] == 1'b0 && bus_rdata[B_VIE] == 1'b0
                     && bus_rdata[B_CIE] == 1'b0));
  p_ctrl_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !any_rst_evt) |=> (bus_rdata[B_CIE] == $past(bus_wdata[B_CIE])));
  p_css_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !css_opt_en |-> (!css_irq && !bus_rdata[B_CFD]));
  p_css_irq_r11: assert property (@(posedge clk) disable iff (!rst_n)
    css_irq |-> (bus_rdata[B_CFD] && bus_rdata[B_CIE]));
endmodule

// File: tb/tb_sysint_status_reg.sv
module tb_sysint_status_reg;
  logic clk = 1'b0;
  logic rst_n;
  logic bus_sel, bus_wr, bus_rd;
  logic [7:0] bus_wdata, bus_rdata;
  logic lvd_opt_en, css_opt_en, vmon_supply_async, vmon_pin_async;
  logic osc_ok_async, css_fail_evt, lvd_rst_evt, wdg_rst_evt, ext_rst_evt;
  logic vmon_irq_ack, vmon_irq, css_irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  sysint_status_reg dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .lvd_opt_en(lvd_opt_en), .css_opt_en(css_opt_en),
    .vmon_supply_async(vmon_supply_async), .vmon_pin_async(vmon_pin_async),
    .osc_ok_async(osc_ok_async), .css_fail_evt(css_fail_evt),
    .lvd_rst_evt(lvd_rst_evt), .wdg_rst_evt(wdg_rst_evt),
    .ext_rst_evt(ext_rst_evt), .vmon_irq_ack(vmon_irq_ack),
    .vmon_irq(vmon_irq), .css_irq(css_irq));

  // bench model of the software-visible state
  logic m_src, m_vie, m_cie, m_lvr, m_wdr;

  function automatic logic [7:0] model_word(logic vf, logic cf);
    return {m_src, m_vie, vf, m_lvr, 1'b0, m_cie, cf, m_wdr};
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic idle();
    bus_sel = 0; bus_wr = 0; bus_rd = 0; css_fail_evt = 0;
    lvd_rst_evt = 0; wdg_rst_evt = 0; ext_rst_evt = 0; vmon_irq_ack = 0;
  endtask

  // one bus cycle with optional reset events; model updated in parallel
  task automatic cycle(logic wr, logic [7:0] wd, logic lv, logic wg, logic ex);
    bus_sel = wr; bus_wr = wr; bus_wdata = wd;
    lvd_rst_evt = lv; wdg_rst_evt = wg; ext_rst_evt = ex;
    if (lv) m_lvr = 1; else if (wr && !wd[4]) m_lvr = 0;
    if (lv) m_wdr = 0; else if (wg) m_wdr = 1; else if (wr && !wd[0]) m_wdr = 0;
    if (lv || wg || ex) begin m_src = 0; m_vie = 0; m_cie = 0; end
    else if (wr) begin m_src = wd[7]; m_vie = wd[6]; m_cie = wd[2]; end
    tick(1);
    idle();
  endtask

  initial begin
    rst_n = 0; bus_wdata = 0; idle();
    lvd_opt_en = 1; css_opt_en = 1; vmon_supply_async = 0;
    vmon_pin_async = 0; osc_ok_async = 0;
    m_src = 0; m_vie = 0; m_cie = 0; m_lvr = 0; m_wdr = 0;
    tick(3);
    rst_n = 1;
    tick(1);
    // R1
    chk("R1 rdata", bus_rdata, 8'h00);
    chk("R1 irqs", {6'b0, vmon_irq, css_irq}, 8'h00);

    // R2: control bits load, read-only and reserved bits ignored
    cycle(1, 8'hFF, 0, 0, 0);
    chk("R2 write all ones", bus_rdata, model_word(0, 0));
    chk("R2 expect", bus_rdata, 8'hC4);
    cycle(1, 8'h2A, 0, 0, 0);
    chk("R2 write 2A", bus_rdata, 8'h00);

    // R4: lvd sets bit4, wdg sets bit0, lvd wins
    cycle(0, 0, 0, 1, 0);
    chk("R4 wdg sets", bus_rdata, 8'h01);
    cycle(0, 0, 1, 1, 0);
    chk("R4 lvd wins", bus_rdata, 8'h10);
    cycle(0, 0, 0, 1, 0);
    chk("R4 both flags", bus_rdata, 8'h11);
    // R3: write 1 keeps, write 0 clears
    cycle(1, 8'h11, 0, 0, 0);
    chk("R3 write ones keep", bus_rdata, 8'h11);
    cycle(1, 8'h10, 0, 0, 0);
    chk("R3 clear bit0", bus_rdata, 8'h10);
    cycle(1, 8'h00, 0, 0, 0);
    chk("R3 clear bit4", bus_rdata, 8'h00);
    // R5: external reset clears controls, keeps flags
    cycle(0, 0, 0, 1, 0);
    cycle(0, 0, 1, 0, 0);
    cycle(0, 0, 0, 1, 0);
    cycle(1, 8'hD5, 0, 0, 0);
    chk("R5 setup", bus_rdata, 8'hD5);
    cycle(0, 0, 0, 0, 1);
    chk("R5 ext keeps flags", bus_rdata, 8'h11);

    // R6/R7: voltage flag through synchronizer, toggle interrupt
    cycle(1, 8'h51, 0, 0, 0);        // vie=1, src=supply
    vmon_supply_async = 1;
    tick(2);
    chk("R6 flag after sync", bus_rdata, 8'h71);
    chk("R7 irq not yet", {7'b0, vmon_irq}, 8'h00);
    tick(1);
    chk("R7 rise pends", {7'b0, vmon_irq}, 8'h01);
    vmon_irq_ack = 1; tick(1); vmon_irq_ack = 0;
    chk("R8 ack clears", {7'b0, vmon_irq}, 8'h00);
    vmon_supply_async = 0;
    tick(3);
    chk("R7 fall pends", {7'b0, vmon_irq}, 8'h01);
    // R8: toggle same cycle as ack wins
    vmon_irq_ack = 1; tick(1); vmon_irq_ack = 0;
    vmon_supply_async = 1;
    tick(2);
    vmon_irq_ack = 1; tick(1); vmon_irq_ack = 0;
    chk("R8 toggle beats ack", {7'b0, vmon_irq}, 8'h01);
    // R5: reset event clears pending
    cycle(0, 0, 0, 0, 1);
    chk("R5 pending cleared", {7'b0, vmon_irq}, 8'h00);
    // R6: source select to pin (pin=0), flag follows pin
    cycle(1, 8'h91, 0, 0, 0);        // src=pin, vie=0
    tick(3);
    chk("R6 pin source", bus_rdata, 8'h91);
    chk("R7 no pend when disabled", {7'b0, vmon_irq}, 8'h00);
    vmon_pin_async = 1; tick(3);
    chk("R6 pin high", bus_rdata, 8'hB1);
    lvd_opt_en = 0; tick(1);
    chk("R6 gated by strap", bus_rdata, 8'h91);
    lvd_opt_en = 1;
    vmon_pin_async = 0; vmon_supply_async = 0;
    cycle(1, 8'h11, 0, 0, 0);
    tick(3);

    // R9/R11: clock failure
    cycle(1, 8'h15, 0, 0, 0);        // css ie
    css_fail_evt = 1; tick(1); css_fail_evt = 0;
    chk("R9 set", bus_rdata, 8'h17);
    chk("R11 irq", {7'b0, css_irq}, 8'h01);
    bus_sel = 1; bus_rd = 1; tick(1); idle();
    chk("R9 read without recovery keeps", bus_rdata, 8'h17);
    css_opt_en = 0; tick(1);
    chk("R10 strap hides bit", bus_rdata, 8'h15);
    chk("R10 irq low", {7'b0, css_irq}, 8'h00);
    css_opt_en = 1;
    cycle(1, 8'h11, 0, 0, 0);
    chk("R11 irq needs enable", {7'b0, css_irq}, 8'h00);
    osc_ok_async = 1; tick(3);
    bus_sel = 1; bus_rd = 1; tick(1); idle();
    chk("R9 read with recovery clears", bus_rdata, 8'h11);
    osc_ok_async = 0;

    // random phase: writes mixed with reset events
    void'($urandom(32'h5EED_1234));
    for (int i = 0; i < 300; i++) begin
      logic [7:0] wd;
      logic wr, lv, wg, ex;
      wd = 8'($urandom);
      wr = ($urandom % 2) == 0;
      lv = ($urandom % 10) == 0;
      wg = ($urandom % 8) == 0;
      ex = ($urandom % 8) == 0;
      cycle(wr, wd, lv, wg, ex);
      chk("R2-R5 random", bus_rdata, model_word(0, 0));
      chk("R7 random no irq", {6'b0, vmon_irq, css_irq}, 8'h00);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    done = 1;
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule